// File: doc/BRIEF.md
# Beam Vector Segment Extractor

This block follows the position of a display beam on a signed fixed-point X/Y grid. On every clock it moves the position by one step and turns the beam's motion into discrete line segment records. Each record carries a start point, an end point and an intensity. The step is normally the signed delta pair presented at the inputs. A low-active homing input replaces the step with the distance to the grid centre, so the beam returns to the centre in a single cycle. A ramp input freezes the beam while it is high.

While the beam is unblanked, the block keeps one open segment. It closes and emits that segment in three cases: the beam is blanked, the step changes, or the intensity changes. After a change of step or intensity, a fresh segment opens at the current point when that point is on the grid. Only points inside the grid, which is bounded by `MAX_X` and `MAX_Y`, can start or extend a segment.

Finished records leave through a valid/ready output that holds one entry. An emit that finds the entry still occupied and not being taken is dropped, and the block reports this on a one-cycle overflow pulse.

Top module: `beam_seg_tracker`

## Requirements
- R1: While reset is high, and in the first cycle after it, the position reads (MAX_X/2, MAX_Y/2), `seg_valid_o` is 0, `overflow_o` is 0 and no segment is open.
- R2: With `home_n_i`=1, each cycle adds the signed (`dx_i`, `dy_i`) to the position when `ramp_i`=0. When `ramp_i`=1 the position does not change.
- R3: With `home_n_i`=0, the position becomes (MAX_X/2, MAX_Y/2) after one clock, whatever the values of `ramp_i`, `dx_i` and `dy_i`.
- R4: The position is a signed two's-complement value of POS_W bits. It can hold values below 0 and at or above MAX without wrapping into the grid.
- R5: With no segment open, `blank_i`=1 and the current point inside 0 <= x < MAX_X and 0 <= y < MAX_Y, a segment opens with its start at the current point. An off-grid current point opens nothing.
- R6: While a segment is open, its end point follows each new position that lies inside the grid. It keeps the last on-grid point once the beam leaves the grid.
- R7: `blank_i`=0 with a segment open emits that segment and closes it.
- R8: With a segment open and `blank_i`=1, a step that differs from the step the segment was opened with emits the segment. A new segment then opens at the current point if that point is on the grid. Otherwise no segment is open afterwards.
- R9: With a segment open and `blank_i`=1, an `inten_i` that differs from the segment's intensity emits the segment and reopens it at the current point. The new segment takes the new intensity.
- R10: An emitted record is on the `seg_*_o` outputs with `seg_valid_o`=1 from the clock edge that emits it. The outputs stay stable while `seg_ready_i`=0. After a cycle with `seg_ready_i`=1 and no new emit, `seg_valid_o` returns to 0.
- R11: An emit while `seg_valid_o`=1 and `seg_ready_i`=0 drops the new record, keeps the old one, and raises `overflow_o` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blank_i | input | 1 | 1 = beam on (unblanked), 0 = beam off |
| home_n_i | input | 1 | 0 = step toward the grid centre |
| ramp_i | input | 1 | 1 = hold the beam still when not homing |
| dx_i | input | DELTA_W | Signed X step per cycle |
| dy_i | input | DELTA_W | Signed Y step per cycle |
| inten_i | input | INT_W | Beam intensity |
| seg_ready_i | input | 1 | Consumer accepts the presented record |
| seg_valid_o | output | 1 | A record is presented |
| seg_x0_o | output | COORD_W | Segment start X |
| seg_y0_o | output | COORD_W | Segment start Y |
| seg_x1_o | output | COORD_W | Segment end X |
| seg_y1_o | output | COORD_W | Segment end Y |
| seg_inten_o | output | INT_W | Segment intensity |
| overflow_o | output | 1 | One-cycle pulse: a record was dropped |
| pos_x_o | output | POS_W | Current signed X position |
| pos_y_o | output | POS_W | Current signed Y position |

## Verification
A wrong position register shows on `pos_x_o`/`pos_y_o` one clock after the faulty step. It also shows later as wrong start or end coordinates in the next record. A stuck or wrong open-segment state shows up at the next blank, step change or intensity change as a missing, extra or misshapen record, one clock after that event. Output-buffer faults appear at once as records that change under backpressure or as a missing overflow pulse.

// File: rtl/beamseg_pkg.sv
package beamseg_pkg;

    localparam int POS_W   = 16;
    localparam int DELTA_W = 8;
    localparam int INT_W   = 8;
    localparam int COORD_W = 12;

    typedef logic signed [POS_W-1:0]   pos_t;
    typedef logic signed [DELTA_W-1:0] delta_t;
    typedef logic [INT_W-1:0]          inten_t;
    typedef logic [COORD_W-1:0]        coord_t;

    typedef enum logic {
        BS_IDLE = 1'b0,
        BS_DRAW = 1'b1
    } bs_state_e;

    typedef struct packed {
        coord_t x0;
        coord_t y0;
        coord_t x1;
        coord_t y1;
        inten_t inten;
    } seg_rec_t;

    function automatic logic pt_inside(pos_t x, pos_t y, pos_t mx, pos_t my);
        return !x[POS_W-1] && (x < mx) && !y[POS_W-1] && (y < my);
    endfunction

    function automatic coord_t to_coord(pos_t v);
        return v[COORD_W-1:0];
    endfunction

endpackage

// File: rtl/beam_step_sel.sv
module beam_step_sel
    import beamseg_pkg::*;
#(
    parameter int MAX_X = 256,
    parameter int MAX_Y = 256
) (
    input  logic   home_n,
    input  logic   ramp,
    input  delta_t dx,
    input  delta_t dy,
    input  pos_t   pos_x,
    input  pos_t   pos_y,
    output pos_t   step_x,
    output pos_t   step_y
);
    localparam pos_t CEN_X = pos_t'(MAX_X / 2);
    localparam pos_t CEN_Y = pos_t'(MAX_Y / 2);

    always_comb begin
        if (!home_n) begin
            step_x = CEN_X - pos_x;
            step_y = CEN_Y - pos_y;
        end else if (ramp) begin
            step_x = '0;
            step_y = '0;
        end else begin
            step_x = pos_t'(dx);
            step_y = pos_t'(dy);
        end
    end
endmodule

// File: rtl/beam_pos_acc.sv
module beam_pos_acc
    import beamseg_pkg::*;
#(
    parameter int MAX_X = 256,
    parameter int MAX_Y = 256
) (
    input  logic clk,
    input  logic rst,
    input  pos_t step_x,
    input  pos_t step_y,
    output pos_t pos_x,
    output pos_t pos_y,
    output pos_t nxt_x,
    output pos_t nxt_y
);
    localparam pos_t CEN_X = pos_t'(MAX_X / 2);
    localparam pos_t CEN_Y = pos_t'(MAX_Y / 2);

    assign nxt_x = pos_x + step_x;
    assign nxt_y = pos_y + step_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_x <= CEN_X;
            pos_y <= CEN_Y;
        end else begin
            pos_x <= nxt_x;
            pos_y <= nxt_y;
        end
    end
endmodule

// File: rtl/beam_seg_fsm.sv
module beam_seg_fsm
    import beamseg_pkg::*;
#(
    parameter int MAX_X = 256,
    parameter int MAX_Y = 256
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     blank,
    input  inten_t   inten,
    input  pos_t     step_x,
    input  pos_t     step_y,
    input  pos_t     pos_x,
    input  pos_t     pos_y,
    input  pos_t     nxt_x,
    input  pos_t     nxt_y,
    output logic     emit,
    output seg_rec_t emit_rec
);
    localparam pos_t LIM_X = pos_t'(MAX_X);
    localparam pos_t LIM_Y = pos_t'(MAX_Y);

    bs_state_e state_q, state_d;
    seg_rec_t  rec_q, rec_d;
    pos_t      sdx_q, sdx_d, sdy_q, sdy_d;
    logic      here_ok, next_ok, reopen, changed;

    always_comb begin
        here_ok = pt_inside(pos_x, pos_y, LIM_X, LIM_Y);
        next_ok = pt_inside(nxt_x, nxt_y, LIM_X, LIM_Y);
        changed = (step_x != sdx_q) || (step_y != sdy_q) || (inten != rec_q.inten);
        state_d = state_q;
        rec_d   = rec_q;
        sdx_d   = sdx_q;
        sdy_d   = sdy_q;
        emit    = 1'b0;
        reopen  = 1'b0;
        case (state_q)
            BS_IDLE: begin
                if (blank && here_ok) begin
                    state_d = BS_DRAW;
                    reopen  = 1'b1;
                end
            end
            BS_DRAW: begin
                if (!blank) begin
                    emit    = 1'b1;
                    state_d = BS_IDLE;
                end else if (changed) begin
                    emit = 1'b1;
                    if (here_ok) reopen  = 1'b1;
                    else         state_d = BS_IDLE;
                end
            end
            default: state_d = BS_IDLE;
        endcase
        if (reopen) begin
            rec_d.x0    = to_coord(pos_x);
            rec_d.y0    = to_coord(pos_y);
            rec_d.x1    = to_coord(pos_x);
            rec_d.y1    = to_coord(pos_y);
            rec_d.inten = inten;
            sdx_d       = step_x;
            sdy_d       = step_y;
        end
        if (state_d == BS_DRAW && next_ok) begin
            rec_d.x1 = to_coord(nxt_x);
            rec_d.y1 = to_coord(nxt_y);
        end
    end

    assign emit_rec = rec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BS_IDLE;
            rec_q   <= '0;
            sdx_q   <= '0;
            sdy_q   <= '0;
        end else begin
            state_q <= state_d;
            rec_q   <= rec_d;
            sdx_q   <= sdx_d;
            sdy_q   <= sdy_d;
        end
    end
endmodule

// File: rtl/beam_seg_outq.sv
module beam_seg_outq
    import beamseg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     emit,
    input  seg_rec_t emit_rec,
    input  logic     ready,
    output logic     valid,
    output seg_rec_t rec,
    output logic     ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            rec   <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= emit && valid && !ready;
            if (emit && (!valid || ready)) begin
                rec   <= emit_rec;
                valid <= 1'b1;
            end else if (ready) begin
                valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/beam_seg_tracker.sv
module beam_seg_tracker
    import beamseg_pkg::*;
#(
    parameter int MAX_X = 256,
    parameter int MAX_Y = 256
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      blank_i,
    input  logic                      home_n_i,
    input  logic                      ramp_i,
    input  logic signed [DELTA_W-1:0] dx_i,
    input  logic signed [DELTA_W-1:0] dy_i,
    input  logic [INT_W-1:0]          inten_i,
    input  logic                      seg_ready_i,
    output logic                      seg_valid_o,
    output logic [COORD_W-1:0]        seg_x0_o,
    output logic [COORD_W-1:0]        seg_y0_o,
    output logic [COORD_W-1:0]        seg_x1_o,
    output logic [COORD_W-1:0]        seg_y1_o,
    output logic [INT_W-1:0]          seg_inten_o,
    output logic                      overflow_o,
    output logic signed [POS_W-1:0]   pos_x_o,
    output logic signed [POS_W-1:0]   pos_y_o
);
    pos_t     step_x, step_y, pos_x, pos_y, nxt_x, nxt_y;
    logic     emit;
    seg_rec_t emit_rec, out_rec;

    beam_step_sel #(.MAX_X(MAX_X), .MAX_Y(MAX_Y)) u_step (
        .home_n (home_n_i), .ramp(ramp_i), .dx(dx_i), .dy(dy_i),
        .pos_x  (pos_x), .pos_y(pos_y), .step_x(step_x), .step_y(step_y)
    );

    beam_pos_acc #(.MAX_X(MAX_X), .MAX_Y(MAX_Y)) u_pos (
        .clk    (clk), .rst(rst), .step_x(step_x), .step_y(step_y),
        .pos_x  (pos_x), .pos_y(pos_y), .nxt_x(nxt_x), .nxt_y(nxt_y)
    );

    beam_seg_fsm #(.MAX_X(MAX_X), .MAX_Y(MAX_Y)) u_fsm (
        .clk    (clk), .rst(rst), .blank(blank_i), .inten(inten_i),
        .step_x (step_x), .step_y(step_y), .pos_x(pos_x), .pos_y(pos_y),
        .nxt_x  (nxt_x), .nxt_y(nxt_y), .emit(emit), .emit_rec(emit_rec)
    );

    beam_seg_outq u_outq (
        .clk    (clk), .rst(rst), .emit(emit), .emit_rec(emit_rec),
        .ready  (seg_ready_i), .valid(seg_valid_o), .rec(out_rec), .ovf(overflow_o)
    );

    assign seg_x0_o    = out_rec.x0;
    assign seg_y0_o    = out_rec.y0;
    assign seg_x1_o    = out_rec.x1;
    assign seg_y1_o    = out_rec.y1;
    assign seg_inten_o = out_rec.inten;
    assign pos_x_o     = pos_x;
    assign pos_y_o     = pos_y;
endmodule

// File: rtl/beam_seg_chk.sv
module beam_seg_chk
    import beamseg_pkg::*;
#(
    parameter int MAX_X = 256,
    parameter int MAX_Y = 256
) (
    input logic   clk,
    input logic   rst,
    input logic   home_n_i,
    input logic   ramp_i,
    input logic   seg_ready_i,
    input logic   seg_valid_o,
    input coord_t seg_x0_o,
    input coord_t seg_y0_o,
    input coord_t seg_x1_o,
    input coord_t seg_y1_o,
    input inten_t seg_inten_o,
    input logic   overflow_o,
    input pos_t   pos_x_o,
    input pos_t   pos_y_o
);
    localparam pos_t CEN_X = pos_t'(MAX_X / 2);
    localparam pos_t CEN_Y = pos_t'(MAX_Y / 2);

    AST_RESET_CENTRE: assert property (@(posedge clk)
        rst |=> (pos_x_o == CEN_X && pos_y_o == CEN_Y && !seg_valid_o && !overflow_o)); // R1

    AST_RAMP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (home_n_i && ramp_i) |=> ($stable(pos_x_o) && $stable(pos_y_o))); // R2

    AST_HOME_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        !home_n_i |=> (pos_x_o == CEN_X && pos_y_o == CEN_Y)); // R3

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
        (seg_valid_o && !seg_ready_i) |=> (seg_valid_o && $stable(seg_x0_o) && $stable(seg_y0_o)
            && $stable(seg_x1_o) && $stable(seg_y1_o) && $stable(seg_inten_o))); // R10

    AST_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (seg_valid_o && !seg_ready_i) |=> !$fell(seg_valid_o)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!seg_valid_o || seg_ready_i) |=> !overflow_o); // R11
endmodule

bind beam_seg_tracker beam_seg_chk #(.MAX_X(MAX_X), .MAX_Y(MAX_Y)) u_chk (
    .clk(clk), .rst(rst), .home_n_i(home_n_i), .ramp_i(ramp_i),
    .seg_ready_i(seg_ready_i), .seg_valid_o(seg_valid_o),
    .seg_x0_o(seg_x0_o), .seg_y0_o(seg_y0_o), .seg_x1_o(seg_x1_o), .seg_y1_o(seg_y1_o),
    .seg_inten_o(seg_inten_o), .overflow_o(overflow_o),
    .pos_x_o(pos_x_o), .pos_y_o(pos_y_o)
);

// File: tb/test_beam_seg_tracker.sv
`timescale 1ns/1ps
module test_beam_seg_tracker;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic blank, home_n, ramp, ready;
    logic signed [7:0] dx, dy;
    logic [7:0] inten;
    logic valid, ovf;
    logic [11:0] x0, y0, x1, y1;
    logic [7:0] sint;
    logic signed [15:0] px, py;
    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    beam_seg_tracker #(.MAX_X(256), .MAX_Y(256)) i_beam_seg_tracker (
        .clk(clk), .rst(rst), .blank_i(blank), .home_n_i(home_n), .ramp_i(ramp),
        .dx_i(dx), .dy_i(dy), .inten_i(inten), .seg_ready_i(ready),
        .seg_valid_o(valid), .seg_x0_o(x0), .seg_y0_o(y0), .seg_x1_o(x1), .seg_y1_o(y1),
        .seg_inten_o(sint), .overflow_o(ovf), .pos_x_o(px), .pos_y_o(py)
    );

    typedef struct packed {
        logic               hn;
        logic               rp;
        logic signed [7:0]  sx;
        logic signed [7:0]  sy;
        logic signed [15:0] ex;
        logic signed [15:0] ey;
    } walk_t;

    // R2, R3 and R4: beam blanked, position walk
    localparam walk_t WALK [8] = '{
        '{1'b1, 1'b0,  8'sd10,  -8'sd5,  16'sd138, 16'sd123},
        '{1'b1, 1'b1,  8'sd50,   8'sd9,  16'sd138, 16'sd123},
        '{1'b1, 1'b0, -8'sd128,  8'sd127, 16'sd10, 16'sd250},
        '{1'b1, 1'b0, -8'sd20,   8'sd10, -16'sd10, 16'sd260},
        '{1'b0, 1'b1,  8'sd5,    8'sd5,  16'sd128, 16'sd128},
        '{1'b1, 1'b0,  8'sd127,  8'sd127, 16'sd255, 16'sd255},
        '{1'b1, 1'b0,  8'sd1,    8'sd0,  16'sd256, 16'sd255},
        '{1'b0, 1'b0,  8'sd3,    8'sd3,  16'sd128, 16'sd128}
    };

    task automatic check_val(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_rec(input string tag, input int ex0, input int ey0,
                             input int ex1, input int ey1, input int ei);
        n_run++;
        if (!valid || x0 != 12'(ex0) || y0 != 12'(ey0) || x1 != 12'(ex1) ||
            y1 != 12'(ey1) || sint != 8'(ei)) begin
            n_fail++;
            $display("FAIL %s: actual v=%0d (%0d,%0d)-(%0d,%0d) i=%0d expected v=1 (%0d,%0d)-(%0d,%0d) i=%0d",
                     tag, valid, x0, y0, x1, y1, sint, ex0, ey0, ex1, ey1, ei);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_in(input logic b, input logic hn, input logic rp,
                          input int sx, input int sy, input int it);
        blank = b; home_n = hn; ramp = rp; dx = 8'(sx); dy = 8'(sy); inten = 8'(it);
    endtask

    task automatic do_reset();
        set_in(1'b0, 1'b1, 1'b1, 0, 0, 0);
        ready = 1'b1;
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check_val("R1 pos_x", px, 128);
        check_val("R1 pos_y", py, 128);
        check_val("R1 valid", valid, 0);
        check_val("R1 overflow", ovf, 0);

        // walk table
        for (int i = 0; i < 8; i++) begin
            set_in(1'b0, WALK[i].hn, WALK[i].rp, WALK[i].sx, WALK[i].sy, 0);
            tick();
            check_val($sformatf("R2/R3/R4 walk%0d x", i), px, WALK[i].ex);
            check_val($sformatf("R2/R3/R4 walk%0d y", i), py, WALK[i].ey);
        end

        // R5 R6 R7: open, extend, blank
        do_reset();
        set_in(1'b1, 1'b1, 1'b0, 2, 1, 50);
        repeat (4) tick();
        set_in(1'b0, 1'b1, 1'b0, 2, 1, 50);
        tick();
        check_rec("R7 blank emit", 128, 128, 136, 132, 50);
        set_in(1'b0, 1'b1, 1'b1, 0, 0, 50);
        tick();
        check_val("R10 drained", valid, 0);

        // R8 R9: step and intensity cuts
        do_reset();
        set_in(1'b1, 1'b1, 1'b0, 1, 0, 10);
        repeat (3) tick();
        set_in(1'b1, 1'b1, 1'b0, 0, 2, 10);
        tick();
        check_rec("R8 step cut", 128, 128, 131, 128, 10);
        set_in(1'b1, 1'b1, 1'b0, 0, 2, 20);
        tick();
        check_rec("R9 intensity cut", 131, 128, 131, 130, 10);
        set_in(1'b0, 1'b1, 1'b0, 0, 2, 20);
        tick();
        check_rec("R9 reopened segment", 131, 130, 131, 132, 20);

        // R3 homing while drawing
        do_reset();
        set_in(1'b1, 1'b1, 1'b0, 10, 0, 5);
        tick();
        set_in(1'b1, 1'b0, 1'b0, 10, 0, 5);
        tick();
        check_rec("R3 home cut", 128, 128, 138, 128, 5);
        check_val("R3 home pos", px, 128);
        set_in(1'b0, 1'b1, 1'b1, 0, 0, 5);
        tick();
        check_rec("R3 home segment", 138, 128, 128, 128, 5);

        // R6 R8 R5: leaving the grid
        do_reset();
        set_in(1'b0, 1'b1, 1'b0, 122, 0, 9);
        tick();
        set_in(1'b1, 1'b1, 1'b0, 4, 0, 9);
        repeat (2) tick();
        set_in(1'b1, 1'b1, 1'b0, 1, 0, 9);
        tick();
        check_rec("R6/R8 off-grid cut", 250, 128, 254, 128, 9);
        tick();
        check_val("R5 no open off grid", valid, 0);
        set_in(1'b0, 1'b1, 1'b0, 1, 0, 9);
        tick();
        check_val("R5 no emit after off grid", valid, 0);

        // R10 R11 backpressure
        do_reset();
        ready = 1'b0;
        set_in(1'b1, 1'b1, 1'b0, 1, 0, 7);
        tick();
        set_in(1'b0, 1'b1, 1'b0, 1, 0, 7);
        tick();
        check_rec("R10 first record", 128, 128, 129, 128, 7);
        set_in(1'b1, 1'b1, 1'b0, 1, 0, 7);
        tick();
        check_rec("R10 held under stall", 128, 128, 129, 128, 7);
        set_in(1'b0, 1'b1, 1'b0, 1, 0, 7);
        tick();
        check_val("R11 overflow pulse", ovf, 1);
        check_rec("R11 old record kept", 128, 128, 129, 128, 7);
        set_in(1'b0, 1'b1, 1'b1, 0, 0, 7);
        tick();
        check_val("R11 overflow one cycle", ovf, 0);
        ready = 1'b1;
        tick();
        check_val("R10 valid clears on accept", valid, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule